// File: doc/BRIEF.md
# Reference-Timed Clock Loss Monitor

This block watches a set of monitored clock inputs from a free-running reference clock, normally the processor clock. Each monitored input goes through a two-flop synchroniser and an edge detector. Every edge it sees restarts a per-channel timeout counter. If an input holds the same level, high or low, for the whole detection window, its loss status is raised. The status drops again on the first edge that follows.

The window is `REF_MHZ * WINDOW_US` reference cycles. The default setting places it inside the 10 to 125 µs band. Any change of a channel's status, into loss or out of it, sets a sticky per-channel delta bit. Software clears a delta bit by writing a one to it. Each delta bit has a mask bit. The interrupt output is the OR of all delta bits whose mask is clear.

Software reaches the block through a small register port. The status, delta and mask registers are each one bit per channel. Reads are combinational from the addressed register, and writes take effect on the reference clock edge.

Top module: `clk_loss_mon`

## Requirements
- R1: After reset, status, delta and mask all read zero and `irq` is low.
- R2: A channel's status (address 0, bit n = channel n) goes to 1 when its input holds one level, high or low, with no edge. It does so no sooner than `REF_MHZ*WINDOW_US` reference cycles and no later than that plus 8 cycles after the last level change.
- R3: A channel in loss returns its status to 0 within 8 reference cycles of the first edge on its input.
- R4: Every change of a channel's status, 0 to 1 or 1 to 0, sets that channel's delta bit (address 1, bit n). The bit stays set until it is cleared.
- R5: Writing to address 1 clears each delta bit whose write-data bit is 1. Delta bits whose write-data bit is 0 are left as they are.
- R6: The mask register (address 2, bit n masks channel n) reads back what was last written. `irq` is 1 exactly when some delta bit is set and its mask bit is 0.
- R7: Writes to address 0 change neither the status nor any other register.
- R8: Channels act independently: loss, recovery and deltas of one channel leave the others untouched.
- R9: Address 3 always reads zero, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mon_clk | input | NUM_CLK | Monitored clock inputs, asynchronous to `ref_clk` |
| reg_addr | input | 2 | Register address: 0 status, 1 delta, 2 mask, 3 unused |
| reg_wr | input | 1 | Write strobe, sampled on `ref_clk` |
| reg_wdata | input | NUM_CLK | Write data |
| reg_rdata | output | NUM_CLK | Read data for the addressed register |
| irq | output | 1 | OR of the unmasked delta bits |

## Verification
Several properties are checked on every cycle:
- the timeout counter never passes its terminal count;
- status rises only when the counter sits at that count;
- any synchronised edge drops the status on the next cycle;
- a status change always leaves its delta bit set;
- a write-one clear takes effect;
- the mask moves only on a mask write.

Other properties are shown only by the bench's scenarios, because they span a full window or depend on the register port:
- the detection window measured from the input pins, for both stuck levels;
- the mixing of stuck and running channels;
- the interrupt under random masks;
- the read-only and unused addresses.

// File: rtl/clm_pkg.sv
package clm_pkg;
  typedef enum logic [1:0] {
    ADDR_STATUS = 2'd0,
    ADDR_DELTA  = 2'd1,
    ADDR_MASK   = 2'd2,
    ADDR_SPARE  = 2'd3
  } clm_addr_e;

  localparam int SYNC_STAGES = 3;
endpackage

// File: rtl/clm_rst_sync.sv
module clm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/clm_chan.sv
module clm_chan #(
  parameter int LIMIT = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mon_i,
  output logic loss_o
);
  import clm_pkg::*;

  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LIM    = CNT_W'(LIMIT);
  localparam logic [CNT_W-1:0] LIM_M1 = CNT_W'(LIMIT - 1);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic [CNT_W-1:0]       cnt_q, cnt_d;
  logic                   loss_q, loss_d;
  logic                   edge_seen;
  logic                   cnt_en;

  // synchroniser and edge detect
  always_comb begin
    sync_d    = {sync_q[SYNC_STAGES-2:0], mon_i};
    edge_seen = sync_q[SYNC_STAGES-1] ^ sync_q[SYNC_STAGES-2];
  end

  // timeout counter and loss flag next state
  always_comb begin
    cnt_en = edge_seen || (cnt_q != LIM);
    cnt_d  = edge_seen ? '0 : cnt_q + 1'b1;
    if (edge_seen)            loss_d = 1'b0;
    else if (cnt_q == LIM_M1) loss_d = 1'b1;
    else                      loss_d = loss_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      cnt_q  <= '0;
      loss_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      if (cnt_en) cnt_q <= cnt_d;
      loss_q <= loss_d;
    end
  end

  assign loss_o = loss_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM); // R2
  AST_RISE_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loss_q) |-> (cnt_q == LIM)); // R2
  AST_EDGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    edge_seen |=> !loss_q); // R3
endmodule

// File: rtl/clm_regs.sv
module clm_regs #(
  parameter int NUM_CLK = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CLK-1:0] loss_i,
  input  logic [1:0]         addr_i,
  input  logic               wr_i,
  input  logic [NUM_CLK-1:0] wdata_i,
  output logic [NUM_CLK-1:0] rdata_o,
  output logic               irq_o
);
  import clm_pkg::*;

  logic [NUM_CLK-1:0] prev_q, delta_q, delta_d, mask_q;
  logic [NUM_CLK-1:0] change, clr;
  logic               mask_en;
  clm_addr_e          addr;

  always_comb begin
    addr    = clm_addr_e'(addr_i);
    change  = loss_i ^ prev_q;
    clr     = (wr_i && addr == ADDR_DELTA) ? wdata_i : '0;
    delta_d = (delta_q & ~clr) | change;
    mask_en = wr_i && (addr == ADDR_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      delta_q <= '0;
      mask_q  <= '0;
    end else begin
      prev_q  <= loss_i;
      delta_q <= delta_d;
      if (mask_en) mask_q <= wdata_i;
    end
  end

  always_comb begin
    case (addr)
      ADDR_STATUS: rdata_o = loss_i;
      ADDR_DELTA:  rdata_o = delta_q;
      ADDR_MASK:   rdata_o = mask_q;
      default:     rdata_o = '0;
    endcase
    irq_o = |(delta_q & ~mask_q);
  end

  AST_MASK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_en |=> $stable(mask_q)); // R6

  for (genvar g = 0; g < NUM_CLK; g++) begin : g_chk
    AST_DELTA_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (loss_i[g] != prev_q[g]) |=> delta_q[g]); // R4
    AST_DELTA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (delta_q[g] && !clr[g]) |=> delta_q[g]); // R5
    AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[g] && !change[g]) |=> !delta_q[g]); // R5
  end
endmodule

// File: rtl/clk_loss_mon.sv
module clk_loss_mon #(
  parameter int NUM_CLK   = 3,
  parameter int REF_MHZ   = 100,
  parameter int WINDOW_US = 40
) (
  input  logic               ref_clk,
  input  logic               rst_n,
  input  logic [NUM_CLK-1:0] mon_clk,
  input  logic [1:0]         reg_addr,
  input  logic               reg_wr,
  input  logic [NUM_CLK-1:0] reg_wdata,
  output logic [NUM_CLK-1:0] reg_rdata,
  output logic               irq
);
  localparam int LIMIT = REF_MHZ * WINDOW_US;

  logic               rst_sync_n;
  logic [NUM_CLK-1:0] loss;

  clm_rst_sync u_rst (
    .clk        (ref_clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar c = 0; c < NUM_CLK; c++) begin : g_chan
    clm_chan #(.LIMIT(LIMIT)) u_chan (
      .clk    (ref_clk),
      .rst_n  (rst_sync_n),
      .mon_i  (mon_clk[c]),
      .loss_o (loss[c])
    );
  end

  clm_regs #(.NUM_CLK(NUM_CLK)) u_regs (
    .clk     (ref_clk),
    .rst_n   (rst_sync_n),
    .loss_i  (loss),
    .addr_i  (reg_addr),
    .wr_i    (reg_wr),
    .wdata_i (reg_wdata),
    .rdata_o (reg_rdata),
    .irq_o   (irq)
  );
endmodule

// File: tb/clk_loss_mon_test.sv
`timescale 1ns/1ps
module clk_loss_mon_test;
  localparam int N     = 3;
  localparam int LIMIT = 100 * 20;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] mon = '0;
  logic [N-1:0] act = '1;
  logic [1:0]   addr = 2'd0;
  logic         wr = 1'b0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] rdata;
  logic         irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [N-1:0] exp_stat = '0, exp_delta = '0, exp_mask = '0;

  clk_loss_mon #(.NUM_CLK(N), .REF_MHZ(100), .WINDOW_US(20)) uut (
    .ref_clk(clk), .rst_n(rst_n), .mon_clk(mon), .reg_addr(addr),
    .reg_wr(wr), .reg_wdata(wdata), .reg_rdata(rdata), .irq(irq)
  );

  always #5 clk = ~clk;

  // monitored clock generator: random toggles while active
  initial begin
    forever begin
      #3;
      for (int i = 0; i < N; i++)
        if (act[i] && ($urandom_range(3) == 0)) mon[i] = ~mon[i];
    end
  end

  function automatic logic exp_irq(logic [N-1:0] d, logic [N-1:0] m);
    return |(d & ~m);
  endfunction

  task automatic chk(string req, logic [31:0] actv, logic [31:0] expv);
    total++;
    if (actv !== expv) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, actv, expv);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [N-1:0] d);
    @(negedge clk);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wrt(input logic [1:0] a, input logic [N-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic upd_stat(input logic [N-1:0] s);
    exp_delta = exp_delta | (exp_stat ^ s);
    exp_stat  = s;
  endtask

  task automatic final_report();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #1_500_000;
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    final_report();
  end

  initial begin
    logic [N-1:0] d, stop_n, newm, clrv;
    void'($urandom(32'h5EED_0042));
    cyc(4);
    rst_n = 1'b1;
    cyc(4);
    // R1 reset state
    rd(2'd0, d); chk("R1 status", d, 0);
    rd(2'd1, d); chk("R1 delta", d, 0);
    rd(2'd2, d); chk("R1 mask", d, 0);
    chk("R1 irq", irq, 0);
    // R9 spare address
    wrt(2'd3, '1);
    rd(2'd3, d); chk("R9 spare reads zero", d, 0);
    rd(2'd2, d); chk("R9 mask untouched", d, 0);
    rd(2'd1, d); chk("R9 delta untouched", d, 0);

    // directed: channel 0 stuck high, others running (R2, R8)
    act[0] = 1'b0; mon[0] = 1'b1;
    cyc(LIMIT - 30);
    rd(2'd0, d); chk("R2 no early loss high", d, 0);
    cyc(60);
    rd(2'd0, d); chk("R2 loss stuck high / R8", d, 3'b001);
    upd_stat(3'b001);
    // R7 write to status ignored
    wrt(2'd0, 3'b110);
    rd(2'd0, d); chk("R7 status unchanged", d, 3'b001);
    rd(2'd2, d); chk("R7 mask unchanged", d, 0);
    rd(2'd1, d); chk("R4 delta on entry", d, exp_delta);
    chk("R6 irq", irq, exp_irq(exp_delta, exp_mask));
    wrt(2'd1, 3'b001); exp_delta = exp_delta & ~3'b001;
    rd(2'd1, d); chk("R5 w1c", d, exp_delta);
    // R3 recovery
    act[0] = 1'b1;
    cyc(30);
    rd(2'd0, d); chk("R3 recover", d, 0);
    upd_stat(3'b000);
    rd(2'd1, d); chk("R4 delta on exit", d, exp_delta);
    wrt(2'd1, '1); exp_delta = '0;

    // random scenarios
    for (int it = 0; it < 18; it++) begin
      stop_n = N'($urandom_range((1 << N) - 1));
      for (int i = 0; i < N; i++) begin
        if (stop_n[i] && act[i]) begin
          act[i] = 1'b0;
          mon[i] = 1'($urandom_range(1));
        end else if (!stop_n[i]) begin
          act[i] = 1'b1;
        end
      end
      cyc(30);
      upd_stat(exp_stat & stop_n);
      rd(2'd0, d); chk("R3 R8 status after restart", d, exp_stat);
      cyc(LIMIT - 70);
      rd(2'd0, d); chk("R2 no early loss", d, exp_stat);
      cyc(70);
      upd_stat(stop_n);
      rd(2'd0, d); chk("R2 R8 loss", d, exp_stat);
      rd(2'd1, d); chk("R4 delta", d, exp_delta);
      newm = N'($urandom_range((1 << N) - 1));
      wrt(2'd2, newm); exp_mask = newm;
      rd(2'd2, d); chk("R6 mask readback", d, exp_mask);
      chk("R6 irq masked", irq, exp_irq(exp_delta, exp_mask));
      clrv = N'($urandom_range((1 << N) - 1));
      wrt(2'd1, clrv); exp_delta = exp_delta & ~clrv;
      rd(2'd1, d); chk("R5 partial w1c", d, exp_delta);
      chk("R6 irq after clear", irq, exp_irq(exp_delta, exp_mask));
    end
    final_report();
  end
endmodule